// File: doc/BRIEF.md
# Three-Wire Serial Configuration Port

This block is the configuration slave of a converter-style device. A host controls it through a serial clock (`ser_clk`), an active-low select (`cs_n`) and one data line that carries data in both directions. On the chip the data line is split into an input (`ser_din`), an output value (`ser_dout`) and an output enable (`ser_doe`). All three pins are brought into the block clock domain through a synchronizer. Edges of the serial clock are found by oversampling it.

Each frame starts with a 16-bit instruction word. The word gives the direction, the number of data bytes and a starting byte address. Whole bytes follow. A write frame stores each byte into a small register file. A read frame turns the line around after the instruction and shifts register contents out. The address steps by one after every byte.

The first register holds a bit that switches the data bytes to least-significant-bit-first order. `cs_n` may rise at a byte boundary to pause a frame. In streaming length it ends the frame. The register file is driven out on `regs_o` for the rest of the device.

If the select is high when reset is released, the port starts in strap mode. In strap mode the clock and data pins act as two static control inputs. The first low level on the select ends strap mode for good, and only a reset brings it back.

Top module: `spi3_cfg_port`

## Requirements
- R1: A frame starts at the first rising serial clock edge that `cs_n` sees low while no frame is open. The first 16 bits are the instruction, always received most significant bit first. Bit 15 gives the direction (1 = read). Bits 14:13 give the length code. Bits 12:0 give the starting byte address. Bits are sampled on rising serial clock edges.
- R2: Length codes 00, 01 and 10 move exactly 1, 2 and 3 data bytes, and then the frame closes. Consecutive bytes go to consecutive addresses. Registers past the last byte are unchanged.
- R3: Length code 11 streams bytes to consecutive addresses for as long as `cs_n` stays low. The frame closes when `cs_n` rises.
- R4: On a read, `ser_doe` rises after the 16th instruction bit. The bit the host samples at each data rising edge is on `ser_dout` before that edge. `ser_doe` is low during the instruction, during write frames and whenever `cs_n` is high.
- R5: Bit 5 of the register at address 0 selects the data-byte order: 0 means most significant bit first, 1 means least significant bit first. Its reset value is 0, and the instruction word does not depend on it.
- R6: A rise of `cs_n` at a byte boundary pauses a fixed-length frame, and the frame resumes at the next byte when `cs_n` falls. Bits of a byte that is only partly received when `cs_n` rises are discarded, and the register file does not change.
- R7: After reset with `cs_n` high, `static_ctl_a_o` follows `ser_clk` and `static_ctl_b_o` follows `ser_din`. Once `cs_n` has been low, both outputs stay 0 until the next reset.
- R8: A write to an address at or beyond the number of registers changes nothing. A read from such an address returns 0x00.
- R9: With `cs_n` held low, a new instruction begins at the rising edge that follows the last bit of a fixed-length frame.
- R10: After reset every register is 0x00 and `ser_doe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low asynchronous reset (power cycle) |
| ser_clk | input | 1 | Serial shift clock from the host |
| cs_n | input | 1 | Active-low select from the host |
| ser_din | input | 1 | Data line, input direction |
| ser_dout | output | 1 | Data line, value to drive during read data |
| ser_doe | output | 1 | Data line output enable |
| static_ctl_a_o | output | 1 | Strap-mode control taken from the clock pin |
| static_ctl_b_o | output | 1 | Strap-mode control taken from the data pin |
| regs_o | output | NUM_REGS*8 | Register file contents, byte i at bits 8i+7:8i |

## Verification
Some rules are checked on every cycle. The output enable stays low whenever the synchronized select is high. It is never active in a cycle that commits a write. The register file changes only in the cycle after a write strobe. Strap mode, once left, never comes back, and its control outputs then stay quiet. Other behaviour can only be shown by the bench scenarios. These cover the instruction decode and length counting, the address stepping, the bit-order switch, the pause and discard rules, the out-of-range addresses and the back-to-back frames, because each one depends on a whole serial sequence.

// File: rtl/spi3_pkg.sv
package spi3_pkg;
   localparam int ADDR_W  = 13;
   localparam int INSTR_W = 16;
   localparam int BYTE_W  = 8;

   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_INSTR = 2'd1,
      PH_DATA  = 2'd2
   } phase_t;
endpackage

// File: rtl/spi3_sync.sv
module spi3_sync #(
   parameter int          W       = 3,
   parameter int          STAGES  = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] chain [STAGES];

   generate
      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= RST_VAL;
               else        chain[s] <= d_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= RST_VAL;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q_o = chain[STAGES-1];
endmodule

// File: rtl/spi3_regfile.sv
module spi3_regfile #(
   parameter int NUM_REGS = 16,
   parameter int ADDR_W   = 13
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     wr_addr,
   input  logic [7:0]            wr_data,
   input  logic [ADDR_W-1:0]     rd_addr,
   output logic [7:0]            rd_data,
   output logic [NUM_REGS*8-1:0] regs_o
);
   logic [7:0] mem [NUM_REGS];

   generate
      for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                  mem[i] <= 8'h00;
            else if (wr_en && wr_addr == ADDR_W'(i))     mem[i] <= wr_data;
         end
         assign regs_o[i*8 +: 8] = mem[i];
      end
   endgenerate

   always_comb begin
      rd_data = 8'h00;
      for (int i = 0; i < NUM_REGS; i++) begin
         if (rd_addr == ADDR_W'(i)) rd_data = mem[i];
      end
   end
endmodule

// File: rtl/spi3_frame.sv
module spi3_frame
   import spi3_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sclk_rise,
   input  logic              csn_s,
   input  logic              din_s,
   input  logic              lsb_first,
   input  logic [7:0]        rd_data,
   output logic [ADDR_W-1:0] rd_addr,
   output logic              wr_en,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [7:0]        wr_data,
   output logic              dout,
   output logic              doe
);
   phase_t            phase_q;
   logic [3:0]        cnt_q;
   logic [14:0]       instr_q;
   logic              rd_q;
   logic              stream_q;
   logic [1:0]        left_q;
   logic [ADDR_W-1:0] addr_q;
   logic [7:0]        sh_q;

   logic [INSTR_W-1:0] instr_full;
   logic [7:0]         byte_full;
   logic [2:0]         bit_idx;

   assign instr_full = {instr_q, din_s};
   assign byte_full  = lsb_first ? {din_s, sh_q[7:1]} : {sh_q[6:0], din_s};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q  <= PH_IDLE;
         cnt_q    <= '0;
         instr_q  <= '0;
         rd_q     <= 1'b0;
         stream_q <= 1'b0;
         left_q   <= '0;
         addr_q   <= '0;
         sh_q     <= '0;
         wr_en    <= 1'b0;
         wr_addr  <= '0;
         wr_data  <= '0;
      end else begin
         wr_en <= 1'b0;
         if (csn_s) begin
            // drop a partial byte, keep the byte boundary reached so far
            cnt_q <= {cnt_q[3], 3'b000};
            if (phase_q == PH_DATA && stream_q) phase_q <= PH_IDLE;
         end else if (sclk_rise) begin
            unique case (phase_q)
               PH_IDLE: begin
                  instr_q <= {14'd0, din_s};
                  cnt_q   <= 4'd1;
                  phase_q <= PH_INSTR;
               end
               PH_INSTR: begin
                  instr_q <= {instr_q[13:0], din_s};
                  if (cnt_q == 4'd15) begin
                     rd_q     <= instr_full[15];
                     stream_q <= &instr_full[14:13];
                     left_q   <= instr_full[14:13];
                     addr_q   <= instr_full[ADDR_W-1:0];
                     cnt_q    <= '0;
                     phase_q  <= PH_DATA;
                  end else begin
                     cnt_q <= cnt_q + 4'd1;
                  end
               end
               PH_DATA: begin
                  sh_q <= byte_full;
                  if (cnt_q[2:0] == 3'd7) begin
                     cnt_q  <= '0;
                     addr_q <= addr_q + 1'b1;
                     if (!rd_q) begin
                        wr_en   <= 1'b1;
                        wr_addr <= addr_q;
                        wr_data <= byte_full;
                     end
                     if (!stream_q) begin
                        if (left_q == 2'd0) phase_q <= PH_IDLE;
                        else                left_q  <= left_q - 2'd1;
                     end
                  end else begin
                     cnt_q <= cnt_q + 4'd1;
                  end
               end
               default: phase_q <= PH_IDLE;
            endcase
         end
      end
   end

   assign rd_addr = addr_q;
   assign bit_idx = lsb_first ? cnt_q[2:0] : (3'd7 - cnt_q[2:0]);
   assign doe     = (phase_q == PH_DATA) && rd_q && !csn_s;
   assign dout    = doe & rd_data[bit_idx];
endmodule

// File: rtl/spi3_cfg_port.sv
module spi3_cfg_port
   import spi3_pkg::*;
#(
   parameter int NUM_REGS    = 16,
   parameter int SYNC_STAGES = 2,
   parameter int CFG_ADDR    = 0,
   parameter int ORDER_BIT   = 5
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ser_clk,
   input  logic                  cs_n,
   input  logic                  ser_din,
   output logic                  ser_dout,
   output logic                  ser_doe,
   output logic                  static_ctl_a_o,
   output logic                  static_ctl_b_o,
   output logic [NUM_REGS*8-1:0] regs_o
);
   localparam int CFG_BIT_POS = CFG_ADDR * BYTE_W + ORDER_BIT;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("spi3_cfg_port: SYNC_STAGES must be at least 2");
      end
      if (NUM_REGS < 1 || NUM_REGS > (1 << ADDR_W)) begin : g_bad_regs
         $error("spi3_cfg_port: NUM_REGS out of range");
      end
      if (CFG_ADDR >= NUM_REGS) begin : g_bad_cfg
         $error("spi3_cfg_port: CFG_ADDR must name an existing register");
      end
      if (ORDER_BIT > 7) begin : g_bad_bit
         $error("spi3_cfg_port: ORDER_BIT must be 0..7");
      end
   endgenerate

   logic [2:0]        pins_s;
   logic              sclk_s, csn_s, din_s, sclk_q, sclk_rise;
   logic              strap_mode;
   logic              wr_en, lsb_first;
   logic [ADDR_W-1:0] wr_addr, rd_addr;
   logic [7:0]        wr_data, rd_data;

   spi3_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   ({ser_clk, cs_n, ser_din}),
      .q_o   (pins_s)
   );
   assign {sclk_s, csn_s, din_s} = pins_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sclk_q <= 1'b0;
      else        sclk_q <= sclk_s;
   end
   assign sclk_rise = sclk_s & ~sclk_q;

   // strap mode: set by reset, cleared for good by the first low select
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         strap_mode     <= 1'b1;
         static_ctl_a_o <= 1'b0;
         static_ctl_b_o <= 1'b0;
      end else begin
         if (!csn_s) strap_mode <= 1'b0;
         static_ctl_a_o <= strap_mode & sclk_s;
         static_ctl_b_o <= strap_mode & din_s;
      end
   end

   assign lsb_first = regs_o[CFG_BIT_POS];

   spi3_frame u_frame (
      .clk       (clk),
      .rst_n     (rst_n),
      .sclk_rise (sclk_rise),
      .csn_s     (csn_s),
      .din_s     (din_s),
      .lsb_first (lsb_first),
      .rd_data   (rd_data),
      .rd_addr   (rd_addr),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .wr_data   (wr_data),
      .dout      (ser_dout),
      .doe       (ser_doe)
   );

   spi3_regfile #(.NUM_REGS(NUM_REGS), .ADDR_W(ADDR_W)) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .regs_o  (regs_o)
   );
endmodule

// File: rtl/spi3_cfg_port_chk.sv
module spi3_cfg_port_chk #(
   parameter int NUM_REGS = 16
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  csn_s,
   input logic                  ser_doe,
   input logic                  wr_en,
   input logic                  strap_mode,
   input logic                  static_ctl_a_o,
   input logic                  static_ctl_b_o,
   input logic [NUM_REGS*8-1:0] regs_o
);
   a_r4_doe_low_when_deselected: assert property (
      @(posedge clk) disable iff (!rst_n) csn_s |-> !ser_doe);

   a_r4_no_drive_during_commit: assert property (
      @(posedge clk) disable iff (!rst_n) !(wr_en && ser_doe));

   a_r6_regs_change_only_on_commit: assert property (
      @(posedge clk) disable iff (!rst_n) !wr_en |=> $stable(regs_o));

   a_r7_select_low_ends_strap: assert property (
      @(posedge clk) disable iff (!rst_n) !csn_s |=> !strap_mode);

   a_r7_strap_never_returns: assert property (
      @(posedge clk) disable iff (!rst_n) !strap_mode |=> !strap_mode);

   a_r7_controls_quiet_after_lock: assert property (
      @(posedge clk) disable iff (!rst_n)
      !strap_mode |=> (!static_ctl_a_o && !static_ctl_b_o));
endmodule

bind spi3_cfg_port spi3_cfg_port_chk #(.NUM_REGS(NUM_REGS)) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .csn_s          (csn_s),
   .ser_doe        (ser_doe),
   .wr_en          (wr_en),
   .strap_mode     (strap_mode),
   .static_ctl_a_o (static_ctl_a_o),
   .static_ctl_b_o (static_ctl_b_o),
   .regs_o         (regs_o)
);

// File: tb/sim_spi3_cfg_port.sv
`timescale 1ns/1ps
module sim_spi3_cfg_port;
   localparam int NR   = 16;
   localparam int HALF = 6;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0;
   logic cs_n = 1'b1;
   logic ser_din = 1'b0;
   logic ser_dout, ser_doe, static_ctl_a_o, static_ctl_b_o;
   logic [NR*8-1:0] regs_o;

   int n_checks = 0;
   int n_fails  = 0;
   logic [7:0] model [NR];
   logic last_oe;

   always #2.5 clk = ~clk;

   spi3_cfg_port #(.NUM_REGS(NR)) u0 (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .cs_n(cs_n),
      .ser_din(ser_din), .ser_dout(ser_dout), .ser_doe(ser_doe),
      .static_ctl_a_o(static_ctl_a_o), .static_ctl_b_o(static_ctl_b_o),
      .regs_o(regs_o)
   );

   task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_fails++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sbit(input logic d, output logic q);
      ser_clk = 1'b0; ser_din = d;
      wait_clk(HALF);
      q = ser_dout; last_oe = ser_doe;
      ser_clk = 1'b1;
      wait_clk(HALF);
   endtask

   task automatic sel_low();
      ser_clk = 1'b0; cs_n = 1'b0; wait_clk(4);
   endtask

   task automatic sel_high();
      ser_clk = 1'b0; cs_n = 1'b1; wait_clk(8);
   endtask

   task automatic instr(input logic rd, input logic [1:0] len, input logic [12:0] a, input string tag);
      logic [15:0] w;
      logic q;
      bit any_oe;
      w = {rd, len, a};
      any_oe = 0;
      for (int i = 15; i >= 0; i--) begin
         sbit(w[i], q);
         if (last_oe) any_oe = 1;
      end
      chk(!any_oe, {tag, " R4 doe low during instruction"}, 32'(any_oe), 0);
   endtask

   task automatic xbyte(input logic [7:0] wb, input bit lsb, output logic [7:0] rb, output bit oe_all);
      logic q;
      oe_all = 1;
      for (int k = 0; k < 8; k++) begin
         int idx;
         idx = lsb ? k : 7 - k;
         sbit(wb[idx], q);
         rb[idx] = q;
         if (!last_oe) oe_all = 0;
      end
   endtask

   task automatic check_regs(input string tag);
      bit ok;
      int bad;
      ok = 1; bad = 0;
      for (int i = NR - 1; i >= 0; i--) begin
         if (regs_o[i*8 +: 8] !== model[i]) begin ok = 0; bad = i; end
      end
      chk(ok, $sformatf("%s register file at byte %0d", tag, bad),
          32'(regs_o[bad*8 +: 8]), 32'(model[bad]));
   endtask

   task automatic wr_frame(input logic [1:0] len, input logic [12:0] a, input int n,
                           input logic [7:0] b0, input logic [7:0] b1,
                           input logic [7:0] b2, input logic [7:0] b3, input bit lsb, input string tag);
      logic [7:0] bs [4];
      logic [7:0] rb;
      bit oe;
      bs[0] = b0; bs[1] = b1; bs[2] = b2; bs[3] = b3;
      sel_low();
      instr(1'b0, len, a, tag);
      for (int i = 0; i < n; i++) xbyte(bs[i], lsb, rb, oe);
      sel_high();
   endtask

   task automatic t_reset();
      chk(ser_doe === 1'b0, "R10 doe low after reset", 32'(ser_doe), 0);
      check_regs("R10 reset");
   endtask

   task automatic t_strap();
      ser_clk = 1'b1; ser_din = 1'b1; wait_clk(6);
      chk(static_ctl_a_o === 1'b1 && static_ctl_b_o === 1'b1, "R7 strap follows pins high",
          {30'd0, static_ctl_a_o, static_ctl_b_o}, 3);
      ser_clk = 1'b0; ser_din = 1'b0; wait_clk(6);
      chk(static_ctl_a_o === 1'b0 && static_ctl_b_o === 1'b0, "R7 strap follows pins low",
          {30'd0, static_ctl_a_o, static_ctl_b_o}, 0);
      sel_low(); sel_high();
      ser_clk = 1'b1; ser_din = 1'b1; wait_clk(6);
      chk(static_ctl_a_o === 1'b0 && static_ctl_b_o === 1'b0, "R7 strap locked after select low",
          {30'd0, static_ctl_a_o, static_ctl_b_o}, 0);
      ser_clk = 1'b0; ser_din = 1'b0; wait_clk(4);
      check_regs("R7 strap traffic");
   endtask

   task automatic t_write_single();
      wr_frame(2'b00, 13'd3, 1, 8'hA5, 8'h00, 8'h00, 8'h00, 0, "R1");
      model[3] = 8'hA5;
      check_regs("R1 single write addr 3");
   endtask

   task automatic t_write_triple();
      wr_frame(2'b10, 13'd5, 3, 8'h11, 8'h22, 8'h33, 8'h00, 0, "R2");
      model[5] = 8'h11; model[6] = 8'h22; model[7] = 8'h33;
      check_regs("R2 three-byte write, addr 8 untouched");
   endtask

   task automatic t_read_pair();
      logic [7:0] rb;
      bit oe;
      sel_low();
      instr(1'b1, 2'b01, 13'd5, "R4");
      xbyte(8'h00, 0, rb, oe);
      chk(rb === 8'h11, "R4 read byte 0", 32'(rb), 32'h11);
      chk(oe, "R4 doe high in read data", 32'(oe), 1);
      xbyte(8'h00, 0, rb, oe);
      chk(rb === 8'h22, "R2 R4 read byte 1 at next address", 32'(rb), 32'h22);
      wait_clk(4);
      chk(ser_doe === 1'b0, "R2 doe released after two-byte read", 32'(ser_doe), 0);
      sel_high();
      chk(ser_doe === 1'b0, "R4 doe low with select high", 32'(ser_doe), 0);
   endtask

   task automatic t_stream();
      logic [7:0] exp [5];
      logic [7:0] rb;
      bit oe;
      wr_frame(2'b11, 13'd9, 4, 8'h9A, 8'hBC, 8'hDE, 8'hF0, 0, "R3");
      model[9] = 8'h9A; model[10] = 8'hBC; model[11] = 8'hDE; model[12] = 8'hF0;
      check_regs("R3 streaming write");
      exp[0] = 8'h9A; exp[1] = 8'hBC; exp[2] = 8'hDE; exp[3] = 8'hF0; exp[4] = 8'h00;
      sel_low();
      instr(1'b1, 2'b11, 13'd9, "R3");
      for (int i = 0; i < 5; i++) begin
         xbyte(8'h00, 0, rb, oe);
         chk(rb === exp[i], $sformatf("R3 streaming read byte %0d", i), 32'(rb), 32'(exp[i]));
      end
      chk(ser_doe === 1'b1, "R3 doe still high while streaming", 32'(ser_doe), 1);
      sel_high();
      chk(ser_doe === 1'b0, "R3 stream closed by select rise", 32'(ser_doe), 0);
   endtask

   task automatic t_pause();
      logic [7:0] rb;
      logic q;
      bit oe;
      sel_low();
      instr(1'b0, 2'b01, 13'd14, "R6");
      xbyte(8'h5C, 0, rb, oe);
      sel_high();
      model[14] = 8'h5C;
      check_regs("R6 first byte before pause");
      sel_low();
      sbit(1'b1, q); sbit(1'b1, q); sbit(1'b1, q);
      sel_high();
      check_regs("R6 partial byte discarded");
      sel_low();
      xbyte(8'h3E, 0, rb, oe);
      sel_high();
      model[15] = 8'h3E;
      check_regs("R6 frame resumed after pause");
      sel_low();
      instr(1'b1, 2'b01, 13'd14, "R6");
      xbyte(8'h00, 0, rb, oe);
      chk(rb === 8'h5C, "R6 read before pause", 32'(rb), 32'h5C);
      sel_high();
      chk(ser_doe === 1'b0, "R4 doe low during read pause", 32'(ser_doe), 0);
      sel_low();
      xbyte(8'h00, 0, rb, oe);
      chk(rb === 8'h3E, "R6 read resumed after pause", 32'(rb), 32'h3E);
      sel_high();
   endtask

   task automatic t_order();
      logic [7:0] rb;
      bit oe;
      wr_frame(2'b00, 13'd0, 1, 8'h20, 8'h00, 8'h00, 8'h00, 0, "R5");
      model[0] = 8'h20;
      check_regs("R5 order bit set");
      wr_frame(2'b00, 13'd2, 1, 8'hC1, 8'h00, 8'h00, 8'h00, 1, "R5");
      model[2] = 8'hC1;
      check_regs("R5 lsb-first write");
      sel_low();
      instr(1'b1, 2'b00, 13'd2, "R5");
      xbyte(8'h00, 1, rb, oe);
      chk(rb === 8'hC1, "R5 lsb-first read", 32'(rb), 32'hC1);
      sel_high();
      wr_frame(2'b00, 13'd0, 1, 8'h00, 8'h00, 8'h00, 8'h00, 1, "R5");
      model[0] = 8'h00;
      wr_frame(2'b00, 13'd1, 1, 8'h81, 8'h00, 8'h00, 8'h00, 0, "R5");
      model[1] = 8'h81;
      check_regs("R5 back to msb-first");
   endtask

   task automatic t_range();
      logic [7:0] rb;
      bit oe;
      wr_frame(2'b00, 13'h100, 1, 8'hFF, 8'h00, 8'h00, 8'h00, 0, "R8");
      check_regs("R8 out-of-range write ignored");
      sel_low();
      instr(1'b1, 2'b00, 13'h1F00, "R8");
      xbyte(8'h00, 0, rb, oe);
      chk(rb === 8'h00, "R8 out-of-range read is zero", 32'(rb), 0);
      sel_high();
   endtask

   task automatic t_back_to_back();
      logic [7:0] rb;
      bit oe;
      sel_low();
      instr(1'b0, 2'b00, 13'd1, "R9");
      xbyte(8'h77, 0, rb, oe);
      instr(1'b0, 2'b00, 13'd4, "R9");
      xbyte(8'h88, 0, rb, oe);
      sel_high();
      model[1] = 8'h77; model[4] = 8'h88;
      check_regs("R9 back-to-back frames");
   endtask

   initial begin
      #(200000 * 5);
      n_fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < NR; i++) model[i] = 8'h00;
      last_oe = 1'b0;
      wait_clk(4);
      rst_n = 1'b1;
      wait_clk(4);
      t_reset();
      t_strap();
      t_write_single();
      t_write_triple();
      t_read_pair();
      t_stream();
      t_pause();
      t_order();
      t_range();
      t_back_to_back();
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
   end
endmodule